// File: doc/BRIEF.md
# External Interrupt Entry Unit

This block decides when a small 32-bit processor core leaves its normal instruction stream to service an external interrupt. Thirty-two request lines feed a sticky pending register. Software controls a mask register, an enable register and an exception base register through a simple register port. At every instruction boundary the unit checks whether any unmasked interrupt is pending while interrupts are enabled.

When it takes an interrupt, the unit raises a redirect flag in the same cycle. It supplies the handler address as the new program counter and writes the current program counter into general register 30, which serves as the return-address register. It also disables further interrupts by replacing the enable register with a value whose saved-enable bit is set and whose live bit is clear.

Software clears pending bits by writing ones to them. A request line that is still high keeps its bit set, so an interrupt that was blocked is taken at the first boundary after the mask or the enable allows it.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset, the IP (csr_sel=0), IM (csr_sel=1), IE (csr_sel=2) and EBA (csr_sel=3) registers all read as zero, and no redirect occurs at an instruction boundary.
- R2: In any cycle where irq_req[i] is 1 at a clock edge, bit i of IP is set after that edge. The bit stays set after irq_req[i] returns to 0.
- R3: A write to IP clears every bit whose csr_wdata bit is 1 and leaves the other bits unchanged. A bit whose request line is high in the same cycle remains set.
- R4: redirect is 1 only in a cycle where insn_done is 1, IE bit 0 is 1, and IM AND IP is nonzero.
- R5: redirect stays 0 in every cycle where insn_done is 0, whatever the pending, mask and enable state.
- R6: When redirect is 1, rf_we is 1, rf_waddr is 30 and rf_wdata equals pc_cur of that cycle.
- R7: When redirect is 1, pc_next equals the EBA value plus 6 times 32 (EBA + 0xC0).
- R8: After an entry, IE reads 0x2: bit 0 (live enable) is clear and bit 1 (saved enable) is set. This holds even if a software write to IE happens in the entry cycle.
- R9: EBA bits 7:0 always read as zero, whatever value is written.
- R10: An interrupt that is pending but blocked by IM or by IE is taken at the first instruction boundary after IM and IE allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 32 | External interrupt request levels, bit i feeds IP bit i |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select: 0 IP, 1 IM, 2 IE, 3 EBA |
| csr_wdata | input | 32 | Register write data (one bits clear for IP; bits 1:0 used for IE) |
| csr_rdata | output | 32 | Combinational read data of the selected register |
| pc_cur | input | 32 | Program counter of the instruction completing |
| insn_done | input | 1 | Instruction-complete strobe, marks a boundary |
| redirect | output | 1 | Interrupt taken in this cycle |
| pc_next | output | 32 | Handler address, valid while redirect is 1 |
| rf_we | output | 1 | Return-address register write enable |
| rf_waddr | output | 5 | Register index written (always 30) |
| rf_wdata | output | 32 | Return address written (pc_cur) |

## Verification
Suppose a pending bit is lost or spuriously set. That error appears at the ports at the next IP readback, or at the next instruction boundary as a missing or unwanted redirect. A wrong IE value after entry shows up as a second redirect at the very next boundary; the correct behaviour is no redirect there. A wrong vector or return address is visible in the entry cycle itself, on pc_next and rf_wdata. The collision between a write-one-to-clear and a live request is exercised directly, because a design in which the clear wins would lose that interrupt permanently.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    CSR_IP  = 2'd0,
    CSR_IM  = 2'd1,
    CSR_IE  = 2'd2,
    CSR_EBA = 2'd3
  } csr_sel_e;

  // IE value after entry: live enable clear, saved enable set
  localparam logic [1:0] IE_AFTER_ENTRY = 2'b10;

endpackage

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] req,
  input  logic               clr_we,
  input  logic [NUM_IRQ-1:0] clr_mask,
  output logic [NUM_IRQ-1:0] ip_q
);

  logic [NUM_IRQ-1:0] clr_eff;
  logic [NUM_IRQ-1:0] ip_d;

  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
  end

  // per-bit: set from the request line wins over the software clear
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
    always_comb begin
      ip_d[i] = req[i] | (ip_q[i] & ~clr_eff[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ip_q <= '0;
    else        ip_q <= ip_d;
  end

endmodule

// File: rtl/irq_csr_bank.sv
module irq_csr_bank #(
  parameter int NUM_IRQ   = 32,
  parameter int XLEN      = 32,
  parameter int EBA_ALIGN = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_im,
  input  logic               we_ie,
  input  logic               we_eba,
  input  logic [XLEN-1:0]    wdata,
  input  logic               entry,
  output logic [NUM_IRQ-1:0] im_q,
  output logic [1:0]         ie_q,
  output logic [XLEN-1:0]    eba_q
);

  import irq_entry_pkg::*;

  localparam logic [XLEN-1:0] EBA_KEEP = ~((XLEN'(1) << EBA_ALIGN) - XLEN'(1));

  function automatic logic [XLEN-1:0] align_base(input logic [XLEN-1:0] v);
    return v & EBA_KEEP;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     im_q <= '0;
    else if (we_im) im_q <= wdata[NUM_IRQ-1:0];
  end

  // entry has priority over a software write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= '0;
    else if (entry) ie_q <= IE_AFTER_ENTRY;
    else if (we_ie) ie_q <= wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      eba_q <= '0;
    else if (we_eba) eba_q <= align_base(wdata);
  end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
  parameter int NUM_IRQ    = 32,
  parameter int XLEN       = 32,
  parameter int EXC_ID     = 6,
  parameter int SLOT_SHIFT = 5
) (
  input  logic [NUM_IRQ-1:0] ip,
  input  logic [NUM_IRQ-1:0] im,
  input  logic               ie_live,
  input  logic               insn_done,
  input  logic [XLEN-1:0]    eba,
  output logic               hit_any,
  output logic               take,
  output logic [XLEN-1:0]    vector
);

  localparam logic [XLEN-1:0] SLOT_OFS = XLEN'(EXC_ID) << SLOT_SHIFT;

  function automatic logic [XLEN-1:0] handler_addr(input logic [XLEN-1:0] base);
    return base + SLOT_OFS;
  endfunction

  always_comb begin
    hit_any = |(ip & im);
    take    = insn_done & ie_live & hit_any;
    vector  = handler_addr(eba);
  end

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit #(
  parameter int NUM_IRQ    = 32,
  parameter int XLEN       = 32,
  parameter int EXC_ID     = 6,
  parameter int SLOT_SHIFT = 5,
  parameter int EBA_ALIGN  = 8,
  parameter int REG_IDX_W  = 5,
  parameter int RA_REG     = 30
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   irq_req,
  input  logic                 csr_we,
  input  logic [1:0]           csr_sel,
  input  logic [XLEN-1:0]      csr_wdata,
  output logic [XLEN-1:0]      csr_rdata,
  input  logic [XLEN-1:0]      pc_cur,
  input  logic                 insn_done,
  output logic                 redirect,
  output logic [XLEN-1:0]      pc_next,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]      rf_wdata
);

  import irq_entry_pkg::*;

  csr_sel_e           sel;
  logic               we_ip, we_im, we_ie, we_eba;
  logic [NUM_IRQ-1:0] ip_q, im_q;
  logic [1:0]         ie_q;
  logic [XLEN-1:0]    eba_q;
  logic               hit_any;
  logic               take_evt;
  logic [XLEN-1:0]    vector;

  always_comb begin
    sel    = csr_sel_e'(csr_sel);
    we_ip  = csr_we && (sel == CSR_IP);
    we_im  = csr_we && (sel == CSR_IM);
    we_ie  = csr_we && (sel == CSR_IE);
    we_eba = csr_we && (sel == CSR_EBA);
  end

  irq_pending_reg #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .clr_we   (we_ip),
    .clr_mask (csr_wdata[NUM_IRQ-1:0]),
    .ip_q     (ip_q)
  );

  irq_csr_bank #(
    .NUM_IRQ  (NUM_IRQ),
    .XLEN     (XLEN),
    .EBA_ALIGN(EBA_ALIGN)
  ) u_csr (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_im  (we_im),
    .we_ie  (we_ie),
    .we_eba (we_eba),
    .wdata  (csr_wdata),
    .entry  (take_evt),
    .im_q   (im_q),
    .ie_q   (ie_q),
    .eba_q  (eba_q)
  );

  irq_entry_ctrl #(
    .NUM_IRQ   (NUM_IRQ),
    .XLEN      (XLEN),
    .EXC_ID    (EXC_ID),
    .SLOT_SHIFT(SLOT_SHIFT)
  ) u_ctrl (
    .ip        (ip_q),
    .im        (im_q),
    .ie_live   (ie_q[0]),
    .insn_done (insn_done),
    .eba       (eba_q),
    .hit_any   (hit_any),
    .take      (take_evt),
    .vector    (vector)
  );

  always_comb begin
    unique case (sel)
      CSR_IP:  csr_rdata = XLEN'(ip_q);
      CSR_IM:  csr_rdata = XLEN'(im_q);
      CSR_IE:  csr_rdata = XLEN'(ie_q);
      default: csr_rdata = eba_q;
    endcase
  end

  always_comb begin
    redirect = take_evt;
    pc_next  = vector;
    rf_we    = take_evt;
    rf_waddr = REG_IDX_W'(RA_REG);
    rf_wdata = pc_cur;
  end

endmodule

// File: rtl/irq_entry_unit_chk.sv
module irq_entry_unit_chk #(
  parameter int NUM_IRQ    = 32,
  parameter int XLEN       = 32,
  parameter int EXC_ID     = 6,
  parameter int SLOT_SHIFT = 5,
  parameter int REG_IDX_W  = 5,
  parameter int RA_REG     = 30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_IRQ-1:0]   irq_req,
  input logic                 csr_we,
  input logic [1:0]           csr_sel,
  input logic                 insn_done,
  input logic                 redirect,
  input logic [XLEN-1:0]      pc_cur,
  input logic [XLEN-1:0]      pc_next,
  input logic                 rf_we,
  input logic [REG_IDX_W-1:0] rf_waddr,
  input logic [XLEN-1:0]      rf_wdata,
  input logic [NUM_IRQ-1:0]   ip_q,
  input logic [NUM_IRQ-1:0]   im_q,
  input logic [1:0]           ie_q,
  input logic [XLEN-1:0]      eba_q
);

  // R2
  req_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |=> ((ip_q & $past(irq_req)) == $past(irq_req)));

  // R3
  pending_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && csr_sel == 2'd0) |=> ((ip_q & $past(ip_q)) == $past(ip_q)));

  // R4
  take_conditions_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (ie_q[0] && ((ip_q & im_q) != '0)));

  // R5
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> insn_done);

  // R6
  return_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (rf_we && rf_waddr == REG_IDX_W'(RA_REG) && rf_wdata == pc_cur));

  // R7
  vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ((pc_next - eba_q) == (XLEN'(EXC_ID) << SLOT_SHIFT)));

  // R8
  ie_after_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (ie_q == 2'b10));

endmodule

bind irq_entry_unit irq_entry_unit_chk #(
  .NUM_IRQ   (NUM_IRQ),
  .XLEN      (XLEN),
  .EXC_ID    (EXC_ID),
  .SLOT_SHIFT(SLOT_SHIFT),
  .REG_IDX_W (REG_IDX_W),
  .RA_REG    (RA_REG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .csr_we    (csr_we),
  .csr_sel   (csr_sel),
  .insn_done (insn_done),
  .redirect  (redirect),
  .pc_cur    (pc_cur),
  .pc_next   (pc_next),
  .rf_we     (rf_we),
  .rf_waddr  (rf_waddr),
  .rf_wdata  (rf_wdata),
  .ip_q      (ip_q),
  .im_q      (im_q),
  .ie_q      (ie_q),
  .eba_q     (eba_q)
);

// File: tb/irq_entry_unit_tb_top.sv
module irq_entry_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_req = '0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [31:0] pc_cur = '0;
  logic        insn_done = 1'b0;
  logic        redirect;
  logic [31:0] pc_next;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  typedef struct {
    bit          take;
    logic [31:0] vec;
    logic [31:0] ret;
    string       req;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] model_eba = '0;

  always #10 clk = ~clk;

  irq_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .pc_cur(pc_cur), .insn_done(insn_done),
    .redirect(redirect), .pc_next(pc_next), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drivers change inputs 2 ns after a rising edge
  task automatic next_slot();
    @(posedge clk);
    #2;
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [31:0] data);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
    next_slot();
    csr_we = 1'b0;
  endtask

  task automatic csr_expect(input string req, input logic [1:0] sel, input logic [31:0] exp);
    csr_sel = sel;
    #1;
    check(req, csr_rdata, exp);
  endtask

  task automatic pulse_irq(input logic [31:0] m);
    irq_req = m;
    next_slot();
    irq_req = '0;
  endtask

  // scoreboard driver: one boundary, expected result pushed for the monitor
  task automatic boundary(input string req, input logic [31:0] pc, input bit take);
    exp_t e;
    e.take = take;
    e.vec  = model_eba + 32'd192;
    e.ret  = pc;
    e.req  = req;
    exp_q.push_back(e);
    pc_cur = pc; insn_done = 1'b1;
    next_slot();
    insn_done = 1'b0;
  endtask

  // monitor: samples at falling edge, far from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (insn_done) begin
        if (exp_q.size() == 0) begin
          check("scoreboard", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.req, " redirect"}, 32'(redirect), 32'(e.take));
          if (e.take) begin
            check("R7 pc_next", pc_next, e.vec);
            check("R6 rf_we", 32'(rf_we), 32'd1);
            check("R6 rf_waddr", 32'(rf_waddr), 32'd30);
            check("R6 rf_wdata", rf_wdata, e.ret);
          end
        end
      end else if (redirect) begin
        check("R5 redirect without boundary", 32'(redirect), 32'd0);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    next_slot();

    // R1 reset state
    csr_expect("R1 IP", 2'd0, 32'h0);
    csr_expect("R1 IM", 2'd1, 32'h0);
    csr_expect("R1 IE", 2'd2, 32'h0);
    csr_expect("R1 EBA", 2'd3, 32'h0);
    boundary("R1 no entry after reset", 32'h100, 1'b0);

    // R2 sticky pending
    pulse_irq(32'h0000_0020);
    next_slot();
    csr_expect("R2 IP bit5 sticky", 2'd0, 32'h0000_0020);
    pulse_irq(32'h8000_0000);
    csr_expect("R2 IP bit31", 2'd0, 32'h8000_0020);

    // R4 blocked: IE clear, IM clear
    boundary("R4 blocked by IE/IM", 32'h104, 1'b0);
    csr_write(2'd1, 32'h0000_0020);
    csr_expect("R4 IM readback", 2'd1, 32'h0000_0020);
    boundary("R4 blocked by IE", 32'h108, 1'b0);

    // R9 EBA alignment
    csr_write(2'd3, 32'h1234_56FF);
    model_eba = 32'h1234_5600;
    csr_expect("R9 EBA low bits", 2'd3, 32'h1234_5600);

    // R10 taken once IE allows it; R5 idle cycles first
    csr_write(2'd2, 32'h1);
    next_slot(); next_slot();
    boundary("R10 entry after IE set", 32'h0000_1000, 1'b1);
    csr_expect("R8 IE after entry", 2'd2, 32'h2);
    boundary("R4 no reentry IE clear", 32'h0000_1004, 1'b0);

    // R3 write-one-to-clear
    csr_write(2'd0, 32'h0000_0020);
    csr_expect("R3 clear bit5 only", 2'd0, 32'h8000_0000);
    irq_req = 32'h0000_0200;
    csr_write(2'd0, 32'h8000_0200);
    irq_req = '0;
    csr_expect("R3 set wins on collision", 2'd0, 32'h0000_0200);

    // R10 blocked by IM, then unmasked
    csr_write(2'd2, 32'h1);
    boundary("R4 blocked by IM", 32'h0000_2000, 1'b0);
    csr_write(2'd1, 32'h0000_0220);
    boundary("R10 entry after IM set", 32'h0000_2004, 1'b1);
    csr_expect("R8 IE after second entry", 2'd2, 32'h2);

    // R8 entry wins over IE write in the same cycle
    csr_write(2'd2, 32'h1);
    csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = 32'h1;
    boundary("R8 entry with IE write", 32'h0000_3000, 1'b1);
    csr_we = 1'b0;
    csr_expect("R8 IE entry priority", 2'd2, 32'h2);

    // R7 vector with a different base
    csr_write(2'd3, 32'hABCD_0000);
    model_eba = 32'hABCD_0000;
    csr_write(2'd2, 32'h3);
    boundary("R7 entry new base", 32'h0000_4000, 1'b1);

    next_slot();
    finished = 1;
    if (exp_q.size() != 0) check("scoreboard drain", 32'(exp_q.size()), 32'd0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule